// File: doc/BRIEF.md
# Card Socket Status and Change Interrupt Unit

This block is the status and control core for a removable-card slot controller that serves one or two sockets. Software talks to it through two byte ports. The first is an index port that holds an address byte. The second is a data port that reads or writes the register that address selects. Each socket samples its card pins through a synchronizer: two card-detect lines, two battery-voltage-detect lines, write protect, ready and power-good. The unit shows these pins live in a status byte. It also latches detect and battery changes into flags that clear when software reads them.

Each socket has a power control byte and a general control byte. The power control byte drives the output-enable, auto-switch, card-enable and Vpp-select outputs. The general control byte drives the card reset line, the I/O-mode flag and the card interrupt routing. A change-interrupt configuration byte chooses which latched flags may interrupt the host. It also chooses which of sixteen host IRQ lines they drive. The outputs of both sockets are merged onto one 16-bit IRQ vector.

Top module: `card_socket_ctrl`

## Requirements
- R1: The index byte is decoded as follows: bit 7 selects the device, bit 6 selects the socket and bits 5:0 select the register. A data access whose device bit differs from DEV_SEL writes nothing and reads 0x00. A read on the index port returns the index byte.
- R2: Register 0x00 reads ID_REV, which is 0x83 by default and has an upper nibble of 0x8. Writes to it are ignored.
- R3: Register 0x01 reads the synchronized pins as follows: [1:0] battery detect, [3:2] card detect, [4] write protect, [5] ready, [6] power good, [7] zero.
- R4: Register 0x02 keeps bits 7, 5, 4 and 1:0, and all other bits read 0. These bits drive out_en_o (bit 7), auto_pwr_o (bit 5), card_en_o (bit 4) and vpp_sel_o (bits 1:0: 1 = 5 V, 2 = 12 V, 0 = off).
- R5: Register 0x03 keeps bits 6, 5 and 3:0. card_rst_o is high while bit 6 is 0. io_mode_o follows bit 5, and card_irq_sel_o follows bits 3:0.
- R6: Register 0x04 latches three flags. Bit 3 is set on any change of the synchronized detect pair. Bit 1 is set when the battery pair changes to 2'b01. Bit 0 is set when battery bit 0 falls.
- R7: A data-port read of register 0x04 returns the latched flags and clears them. Writes to register 0x04 have no effect.
- R8: A change event that coincides with a read of register 0x04 is not returned by that read and stays latched for the next read.
- R9: Register 0x05 keeps bits 7:4 (IRQ number), bit 3 (detect enable), bit 1 (warning enable) and bit 0 (dead enable). irq_o bit N is high while any enabled flag of a socket whose IRQ number is N is set, and irq_o is zero otherwise.
- R10: The two sockets keep separate registers and flags. An access to one socket leaves the other socket's state unchanged.
- R11: After reset, all control registers and flags are 0, so card_rst_o is high and irq_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 1 | Port select: 0 = index port, 1 = data port |
| host_wr_i | input | 1 | Write strobe |
| host_rd_i | input | 1 | Read strobe; qualifies the clear-on-read side effect |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data for the current index, combinational |
| cd_i | input | 2*NUM_SOCKETS | Card detect pair per socket |
| bvd_i | input | 2*NUM_SOCKETS | Battery detect pair per socket |
| wp_i | input | NUM_SOCKETS | Write protect per socket |
| rdy_i | input | NUM_SOCKETS | Card ready per socket |
| pwr_good_i | input | NUM_SOCKETS | Power-applied indication per socket |
| vpp_sel_o | output | 2*NUM_SOCKETS | Vpp select per socket |
| out_en_o | output | NUM_SOCKETS | Card output enable |
| auto_pwr_o | output | NUM_SOCKETS | Automatic power switching enable |
| card_en_o | output | NUM_SOCKETS | Card enable |
| card_rst_o | output | NUM_SOCKETS | Card reset, active high |
| io_mode_o | output | NUM_SOCKETS | I/O-card mode |
| card_irq_sel_o | output | 4*NUM_SOCKETS | Card interrupt routing number |
| irq_o | output | 16 | Status-change interrupt lines, one bit per IRQ number |

## Verification
The bench builds the unit with its defaults: two sockets, device bit 0, identification 0x83 and a two-stage synchronizer. Because both sockets exist, the checks can show that socket 1 state stays apart from socket 0. They can also show each socket driving its own IRQ line. Because the device bit is 0, an index with bit 7 set exercises the foreign-device path. The two-stage synchronizer fixes the event latency at three edges. This lets a read be timed to land on the same edge as a change, which is the case R8 is about.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int IRQ_W   = 4;
  localparam int NUM_IRQ = 1 << IRQ_W;
  localparam int PIN_W   = 7;   // {pg, rdy, wp, cd[1:0], bvd[1:0]}
  localparam int FLAG_W  = 3;   // {cd_chg, bat_warn, bat_dead}

  localparam logic [5:0] REG_ID   = 6'h00;
  localparam logic [5:0] REG_STAT = 6'h01;
  localparam logic [5:0] REG_PWR  = 6'h02;
  localparam logic [5:0] REG_GEN  = 6'h03;
  localparam logic [5:0] REG_CSC  = 6'h04;
  localparam logic [5:0] REG_CFG  = 6'h05;

  localparam logic [7:0] PWR_MASK = 8'hB3;
  localparam logic [7:0] GEN_MASK = 8'h6F;
  localparam logic [7:0] CFG_MASK = 8'hFB;

  typedef struct packed {
    logic       dev;
    logic       sock;
    logic [5:0] sel;
  } index_t;
endpackage

// File: rtl/csc_pin_sync.sv
module csc_pin_sync
  import csc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIN_W-1:0]  pins_i,
  output logic [PIN_W-1:0]  pins_o,
  output logic [FLAG_W-1:0] evt_o
);
  logic [PIN_W-1:0] stg_q [STAGES];
  logic [PIN_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= pins_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign pins_o = stg_q[STAGES-1];

  always_comb begin
    evt_o[2] = pins_o[3:2] != prev_q[3:2];
    evt_o[1] = (pins_o[1:0] == 2'b01) && (prev_q[1:0] != 2'b01);
    evt_o[0] = prev_q[0] && !pins_o[0];
  end
endmodule

// File: rtl/csc_socket_regs.sv
module csc_socket_regs
  import csc_pkg::*;
#(
  parameter logic [7:0] ID_REV = 8'h83
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              csc_rd_i,
  input  logic [5:0]        sel_i,
  input  logic [7:0]        wdata_i,
  input  logic [PIN_W-1:0]  pins_i,
  input  logic [FLAG_W-1:0] evt_i,
  output logic [7:0]        rdata_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [1:0]        vpp_sel_o,
  output logic              out_en_o,
  output logic              auto_pwr_o,
  output logic              card_en_o,
  output logic              card_rst_o,
  output logic              io_mode_o,
  output logic [IRQ_W-1:0]  card_irq_sel_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [7:0]        pwr_q, gen_q, cfg_q;
  logic [FLAG_W-1:0] flag_q;
  logic              pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q <= '0;
      gen_q <= '0;
      cfg_q <= '0;
    end else if (wr_i) begin
      unique case (sel_i)
        REG_PWR: pwr_q <= wdata_i & PWR_MASK;
        REG_GEN: gen_q <= wdata_i & GEN_MASK;
        REG_CFG: cfg_q <= wdata_i & CFG_MASK;
        default: ;
      endcase
    end
  end

  // events on the clearing edge survive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (csc_rd_i ? '0 : flag_q) | evt_i;
  end

  always_comb begin
    unique case (sel_i)
      REG_ID:   rdata_o = ID_REV;
      REG_STAT: rdata_o = {1'b0, pins_i};
      REG_PWR:  rdata_o = pwr_q;
      REG_GEN:  rdata_o = gen_q;
      REG_CSC:  rdata_o = {4'h0, flag_q[2], 1'b0, flag_q[1:0]};
      REG_CFG:  rdata_o = cfg_q;
      default:  rdata_o = 8'h00;
    endcase
  end

  assign pend  = |(flag_q & {cfg_q[3], cfg_q[1], cfg_q[0]});
  assign irq_o = pend ? (NUM_IRQ'(1) << cfg_q[7:4]) : '0;

  assign flags_o        = flag_q;
  assign vpp_sel_o      = pwr_q[1:0];
  assign out_en_o       = pwr_q[7];
  assign auto_pwr_o     = pwr_q[5];
  assign card_en_o      = pwr_q[4];
  assign card_rst_o     = !gen_q[6];
  assign io_mode_o      = gen_q[5];
  assign card_irq_sel_o = gen_q[3:0];
endmodule

// File: rtl/card_socket_ctrl.sv
module card_socket_ctrl
  import csc_pkg::*;
#(
  parameter int         NUM_SOCKETS = 2,
  parameter bit         DEV_SEL     = 1'b0,
  parameter logic [7:0] ID_REV      = 8'h83,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     host_addr_i,
  input  logic                     host_wr_i,
  input  logic                     host_rd_i,
  input  logic [7:0]               host_wdata_i,
  output logic [7:0]               host_rdata_o,
  input  logic [2*NUM_SOCKETS-1:0] cd_i,
  input  logic [2*NUM_SOCKETS-1:0] bvd_i,
  input  logic [NUM_SOCKETS-1:0]   wp_i,
  input  logic [NUM_SOCKETS-1:0]   rdy_i,
  input  logic [NUM_SOCKETS-1:0]   pwr_good_i,
  output logic [2*NUM_SOCKETS-1:0] vpp_sel_o,
  output logic [NUM_SOCKETS-1:0]   out_en_o,
  output logic [NUM_SOCKETS-1:0]   auto_pwr_o,
  output logic [NUM_SOCKETS-1:0]   card_en_o,
  output logic [NUM_SOCKETS-1:0]   card_rst_o,
  output logic [NUM_SOCKETS-1:0]   io_mode_o,
  output logic [4*NUM_SOCKETS-1:0] card_irq_sel_o,
  output logic [15:0]              irq_o
);
  localparam int FL_ALL = FLAG_W * NUM_SOCKETS;

  index_t idx_q;
  logic   dev_hit;
  logic [7:0]         sock_rdata [NUM_SOCKETS];
  logic [NUM_IRQ-1:0] sock_irq   [NUM_SOCKETS];
  logic [FL_ALL-1:0]  flags_all, evt_all;
  logic [NUM_SOCKETS-1:0] csc_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       idx_q <= '0;
    else if (host_wr_i && !host_addr_i) idx_q <= index_t'(host_wdata_i);
  end

  assign dev_hit = idx_q.dev == DEV_SEL;

  for (genvar s = 0; s < NUM_SOCKETS; s++) begin : g_sock
    logic [PIN_W-1:0]  pins;
    logic [FLAG_W-1:0] evt;
    logic              hit;

    assign hit = dev_hit && host_addr_i && (int'(idx_q.sock) == s);
    assign csc_rd[s] = hit && host_rd_i && (idx_q.sel == REG_CSC);

    csc_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pins_i ({pwr_good_i[s], rdy_i[s], wp_i[s], cd_i[2*s +: 2], bvd_i[2*s +: 2]}),
      .pins_o (pins),
      .evt_o  (evt)
    );

    csc_socket_regs #(.ID_REV(ID_REV)) i_regs (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wr_i           (hit && host_wr_i),
      .csc_rd_i       (csc_rd[s]),
      .sel_i          (idx_q.sel),
      .wdata_i        (host_wdata_i),
      .pins_i         (pins),
      .evt_i          (evt),
      .rdata_o        (sock_rdata[s]),
      .flags_o        (flags_all[FLAG_W*s +: FLAG_W]),
      .vpp_sel_o      (vpp_sel_o[2*s +: 2]),
      .out_en_o       (out_en_o[s]),
      .auto_pwr_o     (auto_pwr_o[s]),
      .card_en_o      (card_en_o[s]),
      .card_rst_o     (card_rst_o[s]),
      .io_mode_o      (io_mode_o[s]),
      .card_irq_sel_o (card_irq_sel_o[4*s +: 4]),
      .irq_o          (sock_irq[s])
    );

    assign evt_all[FLAG_W*s +: FLAG_W] = evt;
  end

  always_comb begin
    host_rdata_o = idx_q;
    if (host_addr_i) begin
      host_rdata_o = 8'h00;
      for (int s = 0; s < NUM_SOCKETS; s++)
        if (dev_hit && int'(idx_q.sock) == s) host_rdata_o = sock_rdata[s];
    end
  end

  always_comb begin
    irq_o = '0;
    for (int s = 0; s < NUM_SOCKETS; s++) irq_o |= sock_irq[s];
  end
endmodule

// File: rtl/card_socket_ctrl_chk.sv
module card_socket_ctrl_chk #(
  parameter int NUM_SOCKETS = 2,
  parameter bit DEV_SEL     = 1'b0
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     host_addr_i,
  input logic                     host_wr_i,
  input logic [7:0]               idx,
  input logic [3*NUM_SOCKETS-1:0] flags_all,
  input logic [3*NUM_SOCKETS-1:0] evt_all,
  input logic [NUM_SOCKETS-1:0]   csc_rd,
  input logic [15:0]              irq_o,
  input logic [9*NUM_SOCKETS-1:0] ctl
);
  AST_IRQ_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= NUM_SOCKETS);                                     // R9
  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_all == '0) |-> (irq_o == '0));                                  // R9
  AST_FOREIGN_DEV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_addr_i && (idx[7] != DEV_SEL)) |=> $stable(ctl));   // R1

  for (genvar s = 0; s < NUM_SOCKETS; s++) begin : g_s
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !csc_rd[s] |=> ((flags_all[3*s +: 3] & $past(flags_all[3*s +: 3]))
                      == $past(flags_all[3*s +: 3])));                     // R7
    AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      csc_rd[s] |=> ((flags_all[3*s +: 3] & $past(flags_all[3*s +: 3])
                      & ~$past(evt_all[3*s +: 3])) == '0));                // R7
    AST_EVENT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_all[3*s +: 3] != '0) |=> ((flags_all[3*s +: 3] & $past(evt_all[3*s +: 3]))
                                     == $past(evt_all[3*s +: 3])));        // R8
  end
endmodule

bind card_socket_ctrl card_socket_ctrl_chk #(
  .NUM_SOCKETS (NUM_SOCKETS),
  .DEV_SEL     (DEV_SEL)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_addr_i (host_addr_i),
  .host_wr_i   (host_wr_i),
  .idx         (idx_q),
  .flags_all   (flags_all),
  .evt_all     (evt_all),
  .csc_rd      (csc_rd),
  .irq_o       (irq_o),
  .ctl         ({vpp_sel_o, out_en_o, auto_pwr_o, card_en_o, card_rst_o, io_mode_o, card_irq_sel_o})
);

// File: tb/test_card_socket_ctrl.sv
`timescale 1ns/1ps
module test_card_socket_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [3:0] cd = '0, bvd = '0;
  logic [1:0] wp = '0, rdy = '0, pg = '0;
  logic [3:0] vpp_sel;
  logic [1:0] out_en, auto_pwr, card_en, card_rst, io_mode;
  logic [7:0] irq_sel;
  logic [15:0] irq;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  card_socket_ctrl i_card_socket_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(host_addr), .host_wr_i(host_wr),
    .host_rd_i(host_rd), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .cd_i(cd), .bvd_i(bvd), .wp_i(wp), .rdy_i(rdy), .pwr_good_i(pg),
    .vpp_sel_o(vpp_sel), .out_en_o(out_en), .auto_pwr_o(auto_pwr), .card_en_o(card_en),
    .card_rst_o(card_rst), .io_mode_o(io_mode), .card_irq_sel_o(irq_sel), .irq_o(irq));

  // {index, write data, expected readback}
  localparam logic [23:0] VEC [11] = '{
    {8'h02, 8'hB1, 8'hB1}, {8'h02, 8'hFF, 8'hB3}, {8'h03, 8'h65, 8'h65},
    {8'h03, 8'hFF, 8'h6F}, {8'h05, 8'hFF, 8'hFB}, {8'h05, 8'h38, 8'h38},
    {8'h42, 8'h90, 8'h90}, {8'h00, 8'h55, 8'h83}, {8'h04, 8'hFF, 8'h00},
    {8'h3F, 8'hAA, 8'h00}, {8'h82, 8'hFF, 8'h00}};
  localparam string VREQ [11] = '{"R4", "R4", "R5", "R5", "R9", "R9",
                                  "R10", "R2", "R7", "R1", "R1"};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R11 reset state
    rd(1'b0, rv);
    check("R11 index", rv, 8'h00);
    check("R11 irq", irq, 16'h0000);
    check("R11 card_rst", card_rst, 2'b11);
    check("R11 out_en", out_en, 2'b00);

    for (int i = 0; i < 11; i++) begin
      wr(1'b0, VEC[i][23:16]);
      wr(1'b1, VEC[i][15:8]);
      rd(1'b1, rv);
      check(VREQ[i], rv, VEC[i][7:0]);
    end

    // R4 / R5 outputs
    check("R4 out_en", out_en, 2'b11);
    check("R4 auto_pwr", auto_pwr, 2'b01);
    check("R4 card_en", card_en, 2'b11);
    check("R4 vpp_sel", vpp_sel, 4'h3);
    check("R5 card_rst", card_rst, 2'b10);
    check("R5 io_mode", io_mode, 2'b01);
    check("R5 irq_sel", irq_sel, 8'h0F);

    // R3 status byte, R6 detect change, R9 routing
    cd[1:0] = 2'b11; bvd[1:0] = 2'b11; wp[0] = 1'b1; rdy[0] = 1'b1; pg[0] = 1'b1;
    wait_n(4);
    wr(1'b0, 8'h01); rd(1'b1, rv);
    check("R3 status", rv, 8'h7F);
    check("R9 irq line 3", irq, 16'h0008);
    wr(1'b0, 8'h04); rd(1'b1, rv);
    check("R6 detect flag", rv, 8'h08);
    rd(1'b1, rv);
    check("R7 cleared", rv, 8'h00);
    check("R9 irq dropped", irq, 16'h0000);

    // R6 battery warning, R9 enable gating
    bvd[1:0] = 2'b01;
    wait_n(4);
    check("R9 disabled flag", irq, 16'h0000);
    wr(1'b0, 8'h05); wr(1'b1, 8'h3A);
    check("R9 warn enabled", irq, 16'h0008);
    wr(1'b0, 8'h04); rd(1'b1, rv);
    check("R6 warn flag", rv, 8'h02);
    check("R9 irq after clear", irq, 16'h0000);

    // R6 battery dead
    bvd[1:0] = 2'b00;
    wait_n(4);
    rd(1'b1, rv);
    check("R6 dead flag", rv, 8'h01);

    // R8 event on the clearing edge
    cd[1:0] = 2'b00;
    wait_n(2);
    rd(1'b1, rv);
    check("R8 same-edge read", rv, 8'h00);
    rd(1'b1, rv);
    check("R8 kept", rv, 8'h08);

    // R7 write does not clear
    cd[1:0] = 2'b11;
    wait_n(4);
    wr(1'b1, 8'hFF);
    rd(1'b1, rv);
    check("R7 write ignored", rv, 8'h08);

    // R10 socket 1
    wr(1'b0, 8'h45); wr(1'b1, 8'h78);
    cd[3:2] = 2'b11;
    wait_n(4);
    check("R10 irq line 7", irq, 16'h0080);
    wr(1'b0, 8'h04); rd(1'b1, rv);
    check("R10 socket0 quiet", rv, 8'h00);
    wr(1'b0, 8'h44); rd(1'b1, rv);
    check("R10 socket1 flag", rv, 8'h08);
    check("R10 irq cleared", irq, 16'h0000);

    // R1 foreign device
    wr(1'b0, 8'h81); rd(1'b1, rv);
    check("R1 foreign read", rv, 8'h00);
    wr(1'b0, 8'h02); rd(1'b1, rv);
    check("R1 foreign write dropped", rv, 8'hB3);
    rd(1'b0, rv);
    check("R1 index readback", rv, 8'h02);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule